// File: doc/BRIEF.md
# Modulator End-of-Cycle Request Controller

This block keeps the end-of-cycle status flag of a carrier modulator and routes it to one of two request outputs: an interrupt request or a DMA request. The flag is raised when the modulator is first enabled from idle, and again each time the period counter reloads while the enable bit stays on. Two control bits decide what the flag does. A request-enable bit allows the flag to reach either output at all. A DMA-select bit picks which output it reaches.

How the flag is cleared depends on the routing mode. In interrupt mode, software reads the status register and then accesses one of the clearing data registers. In DMA mode, the completion strobe of the transfer clears it. The carrier generator, the counter datapath and the bus decoder sit outside this block. They deliver single-cycle strobes to it.

Top module: `eoc_req_ctrl`

## Requirements
- R1: While the flag is 0, `irq_req` and `dma_req` are both 0, for any setting of `req_en` and `dma_sel`.
- R2: While the flag is 1 and `req_en` is 0, `irq_req` and `dma_req` are both 0.
- R3: While the flag is 1 and `req_en` is 1, `irq_req` is 1 and `dma_req` is 0 when `dma_sel` is 0. When `dma_sel` is 1, `dma_req` is 1 and `irq_req` is 0. The requests follow the flag and the control bits combinationally.
- R4: The flag is 1 in the cycle after `mod_en` is 1 and was 0 at the previous clock edge, provided `mod_busy` is 0.
- R5: The flag is 1 in the cycle after `eoc_pulse` is 1 while `mod_en` is 1.
- R6: A rising `mod_en` while `mod_busy` is 1 does not set the flag. The next `eoc_pulse` with `mod_en` at 1 sets it.
- R7: An `eoc_pulse` while `mod_en` is 0 does not set the flag.
- R8: When `dma_sel` is 0, a `stat_rd` seen while the flag is 1 arms the clear. A later cycle with any bit of `clr_acc` at 1 then clears the flag in the next cycle. An access without a prior arming read does not clear the flag. An access in the same cycle as the arming read does not clear it either. A `stat_rd` while the flag is 0 does not arm.
- R9: When `dma_sel` is 1, `xfer_done` clears the flag in the next cycle, and the read-then-access sequence has no effect. When `dma_sel` is 0, `xfer_done` has no effect.
- R10: A flag-set event disarms a pending arming read, so an access after a re-set does not clear the flag.
- R11: If a set event and a clear event fall in the same cycle, the flag is 1 afterwards.
- R12: A synchronous active-high `rst` clears the flag, the arming state and both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator enable bit |
| mod_busy | input | 1 | Modulator currently in a cycle |
| eoc_pulse | input | 1 | Counter reload strobe at the end of a modulation cycle |
| req_en | input | 1 | Request enable control bit |
| dma_sel | input | 1 | 1 routes to DMA, 0 routes to interrupt |
| stat_rd | input | 1 | Status-register read strobe |
| clr_acc | input | NUM_CLR | Access strobes of the clearing data registers |
| xfer_done | input | 1 | DMA transfer completion strobe |
| eoc_flag | output | 1 | End-of-cycle status flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with NUM_CLR at its default of 2. This lets it check that either clearing register completes the read-then-access sequence, that each one is decoded on its own bit, and that the two are combined by OR. Directed cases cover each ordering that matters: an access in the same cycle as the arming read, a read while the flag is clear, a set coinciding with a clear, and a re-enable during a busy cycle. A long run of random strobes and mode changes then compares all three outputs every cycle against a behavioural model, including random reset pulses.

// File: rtl/eoc_req_pkg.sv
package eoc_req_pkg;

    typedef struct packed {
        logic req_en;
        logic dma_sel;
    } route_ctrl_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_IRQ  = 2'd1,
        ROUTE_DMA  = 2'd2
    } route_e;

    function automatic route_e route_of(input logic flag, input route_ctrl_t c);
        if (!flag || !c.req_en) return ROUTE_NONE;
        return c.dma_sel ? ROUTE_DMA : ROUTE_IRQ;
    endfunction

endpackage

// File: rtl/eoc_set_detect.sv
module eoc_set_detect (
    input  logic clk,
    input  logic mod_en,
    input  logic mod_busy,
    input  logic eoc_pulse,
    output logic set_ev
);
    logic en_q;

    // Follows the enable in every cycle, including reset, so that an enable
    // already high when reset is released does not count as a fresh start.
    always_ff @(posedge clk) begin
        en_q <= mod_en;
    end

    logic start_ev;
    logic reload_ev;

    always_comb begin
        start_ev  = mod_en && !en_q && !mod_busy;
        reload_ev = eoc_pulse && mod_en;
        set_ev    = start_ev || reload_ev;
    end
endmodule

// File: rtl/eoc_flag_core.sv
module eoc_flag_core (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic dma_sel,
    input  logic stat_rd,
    input  logic any_acc,
    input  logic xfer_done,
    output logic flag
);
    logic armed_q;
    logic sw_clear;
    logic dma_clear;
    logic clr_ev;

    always_comb begin
        sw_clear  = !dma_sel && armed_q && any_acc;
        dma_clear = dma_sel && xfer_done;
        clr_ev    = sw_clear || dma_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            // A set wins over a clear in the same cycle.
            if (set_ev)      flag <= 1'b1;
            else if (clr_ev) flag <= 1'b0;

            if (set_ev)
                armed_q <= 1'b0;
            else if (!dma_sel && armed_q && any_acc)
                armed_q <= 1'b0;
            else if (!dma_sel && stat_rd && flag)
                armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/eoc_req_steer.sv
module eoc_req_steer
    import eoc_req_pkg::*;
(
    input  logic        flag,
    input  route_ctrl_t ctrl,
    output logic        irq_req,
    output logic        dma_req
);
    route_e route;

    always_comb begin
        route   = route_of(flag, ctrl);
        irq_req = (route == ROUTE_IRQ);
        dma_req = (route == ROUTE_DMA);
    end
endmodule

// File: rtl/eoc_req_ctrl.sv
module eoc_req_ctrl
    import eoc_req_pkg::*;
#(
    parameter int NUM_CLR = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mod_en,
    input  logic               mod_busy,
    input  logic               eoc_pulse,
    input  logic               req_en,
    input  logic               dma_sel,
    input  logic               stat_rd,
    input  logic [NUM_CLR-1:0] clr_acc,
    input  logic               xfer_done,
    output logic               eoc_flag,
    output logic               irq_req,
    output logic               dma_req
);
    logic        set_ev;
    logic        any_acc;
    route_ctrl_t ctrl;

    always_comb begin
        any_acc      = |clr_acc;
        ctrl.req_en  = req_en;
        ctrl.dma_sel = dma_sel;
    end

    eoc_set_detect u_set (
        .clk       (clk),
        .mod_en    (mod_en),
        .mod_busy  (mod_busy),
        .eoc_pulse (eoc_pulse),
        .set_ev    (set_ev)
    );

    eoc_flag_core u_flag (
        .clk       (clk),
        .rst       (rst),
        .set_ev    (set_ev),
        .dma_sel   (dma_sel),
        .stat_rd   (stat_rd),
        .any_acc   (any_acc),
        .xfer_done (xfer_done),
        .flag      (eoc_flag)
    );

    eoc_req_steer u_steer (
        .flag    (eoc_flag),
        .ctrl    (ctrl),
        .irq_req (irq_req),
        .dma_req (dma_req)
    );
endmodule

// File: rtl/eoc_req_chk.sv
module eoc_req_chk #(
    parameter int NUM_CLR = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               mod_en,
    input logic               mod_busy,
    input logic               eoc_pulse,
    input logic               req_en,
    input logic               dma_sel,
    input logic               stat_rd,
    input logic [NUM_CLR-1:0] clr_acc,
    input logic               xfer_done,
    input logic               eoc_flag,
    input logic               irq_req,
    input logic               dma_req
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc_flag |-> (!irq_req && !dma_req));

    // R2
    gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_flag && !req_en) |-> (!irq_req && !dma_req));

    // R3
    one_route_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({irq_req, dma_req}) <= 1);

    // R4
    start_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_en && !$past(mod_en) && !mod_busy) |=> eoc_flag);

    // R5
    reload_set_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_pulse && mod_en) |=> eoc_flag);

    // R7
    off_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_pulse && !mod_en && !eoc_flag) |=> !eoc_flag);

    // R9
    dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_sel && eoc_flag && !xfer_done) |=> eoc_flag);

    // R9
    dma_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_sel && xfer_done && !eoc_pulse && !mod_en) |=> !eoc_flag);

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!eoc_flag && !irq_req && !dma_req));

    logic unused_ok;
    always_comb unused_ok = stat_rd ^ (|clr_acc);
endmodule

bind eoc_req_ctrl eoc_req_chk #(.NUM_CLR(NUM_CLR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_en    (mod_en),
    .mod_busy  (mod_busy),
    .eoc_pulse (eoc_pulse),
    .req_en    (req_en),
    .dma_sel   (dma_sel),
    .stat_rd   (stat_rd),
    .clr_acc   (clr_acc),
    .xfer_done (xfer_done),
    .eoc_flag  (eoc_flag),
    .irq_req   (irq_req),
    .dma_req   (dma_req)
);

// File: tb/eoc_req_ctrl_tb_top.sv
`timescale 1ns/100ps
module eoc_req_ctrl_tb_top;
    localparam int NCLR = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mod_en = 1'b0, mod_busy = 1'b0, eoc_pulse = 1'b0;
    logic            req_en = 1'b0, dma_sel = 1'b0, stat_rd = 1'b0;
    logic [NCLR-1:0] clr_acc = '0;
    logic            xfer_done = 1'b0;
    logic            eoc_flag, irq_req, dma_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference state
    bit m_flag = 0, m_armed = 0, m_en_prev = 0;

    always #2.5 clk = ~clk;

    eoc_req_ctrl #(.NUM_CLR(NCLR)) dut_i (
        .clk(clk), .rst(rst), .mod_en(mod_en), .mod_busy(mod_busy),
        .eoc_pulse(eoc_pulse), .req_en(req_en), .dma_sel(dma_sel),
        .stat_rd(stat_rd), .clr_acc(clr_acc), .xfer_done(xfer_done),
        .eoc_flag(eoc_flag), .irq_req(irq_req), .dma_req(dma_req)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit ei, ed;
        ei = m_flag && req_en && !dma_sel;
        ed = m_flag && req_en && dma_sel;
        chk("R11 model flag", eoc_flag, m_flag);
        chk("R3 model irq_req", irq_req, ei);
        chk("R3 model dma_req", dma_req, ed);
    endtask

    // One clock: predict from the inputs at the edge, then compare just after.
    task automatic step();
        bit nf, na, setb, clrb, accb;
        setb = (mod_en && !m_en_prev && !mod_busy) || (eoc_pulse && mod_en);
        accb = (clr_acc != 0);
        clrb = (!dma_sel && m_armed && accb) || (dma_sel && xfer_done);
        if (rst) begin
            nf = 0; na = 0;
        end else begin
            nf = setb ? 1 : (clrb ? 0 : m_flag);
            if (setb) na = 0;
            else if (!dma_sel && m_armed && accb) na = 0;
            else if (!dma_sel && stat_rd && m_flag) na = 1;
            else na = m_armed;
        end
        @(posedge clk);
        #1;
        m_en_prev = mod_en;
        m_flag = nf;
        m_armed = na;
        stat_rd = 0; clr_acc = '0; xfer_done = 0; eoc_pulse = 0;
        compare_model();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1;
        step(); step();
        chk("R12 flag after reset", eoc_flag, 0);
        chk("R12 irq after reset", irq_req, 0);
        chk("R12 dma after reset", dma_req, 0);
        rst = 0; req_en = 1; dma_sel = 0;
        step();
        chk("R1 irq with flag clear", irq_req, 0);
        chk("R1 dma with flag clear", dma_req, 0);

        mod_en = 1; mod_busy = 0; step();
        chk("R4 start sets flag", eoc_flag, 1);
        chk("R3 irq routed", irq_req, 1);
        chk("R3 dma off in irq mode", dma_req, 0);

        req_en = 0; step();
        chk("R2 irq gated", irq_req, 0);
        chk("R2 dma gated", dma_req, 0);
        req_en = 1;

        clr_acc = 2'b01; step();
        chk("R8 access without read keeps flag", eoc_flag, 1);
        stat_rd = 1; clr_acc = 2'b01; step();
        chk("R8 access with read same cycle keeps flag", eoc_flag, 1);
        clr_acc = 2'b10; step();
        chk("R8 read then access clears", eoc_flag, 0);

        stat_rd = 1; step();
        eoc_pulse = 1; step();
        chk("R5 reload sets flag", eoc_flag, 1);
        clr_acc = 2'b01; step();
        chk("R8 read while clear did not arm", eoc_flag, 1);

        stat_rd = 1; step();
        eoc_pulse = 1; step();
        clr_acc = 2'b10; step();
        chk("R10 set disarms pending read", eoc_flag, 1);

        stat_rd = 1; step();
        eoc_pulse = 1; clr_acc = 2'b01; step();
        chk("R11 set beats clear", eoc_flag, 1);

        dma_sel = 1; step();
        chk("R3 dma routed", dma_req, 1);
        chk("R3 irq held off", irq_req, 0);
        stat_rd = 1; step();
        clr_acc = 2'b01; step();
        chk("R9 read-access ignored in dma mode", eoc_flag, 1);
        xfer_done = 1; step();
        chk("R9 transfer done clears", eoc_flag, 0);
        chk("R1 dma drops with flag", dma_req, 0);

        dma_sel = 0; eoc_pulse = 1; step();
        xfer_done = 1; step();
        chk("R9 transfer done ignored in irq mode", eoc_flag, 1);
        stat_rd = 1; step();
        clr_acc = 2'b10; step();

        mod_en = 0; step();
        eoc_pulse = 1; step();
        chk("R7 reload with enable off no set", eoc_flag, 0);

        mod_busy = 1; step();
        mod_en = 1; step();
        chk("R6 re-enable while busy no set", eoc_flag, 0);
        eoc_pulse = 1; step();
        chk("R6 set at end of current cycle", eoc_flag, 1);

        rst = 1; step();
        chk("R12 mid-run reset clears flag", eoc_flag, 0);
        chk("R12 mid-run reset clears irq", irq_req, 0);
        rst = 0;

        for (int i = 0; i < 3000; i++) begin
            rst       = ($urandom_range(0, 199) == 0);
            mod_en    = ($urandom_range(0, 9) != 0) ? mod_en : ~mod_en;
            mod_busy  = $urandom_range(0, 1);
            eoc_pulse = ($urandom_range(0, 5) == 0);
            req_en    = ($urandom_range(0, 7) != 0);
            dma_sel   = ($urandom_range(0, 39) == 0) ? ~dma_sel : dma_sel;
            stat_rd   = ($urandom_range(0, 3) == 0);
            clr_acc   = ($urandom_range(0, 3) == 0) ? NCLR'($urandom_range(1, 3)) : '0;
            xfer_done = ($urandom_range(0, 4) == 0);
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule